// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Fall-Through Read

This block is a first-in first-out queue for one clock domain. It stores words in an inferred dual-port memory, tracks its occupancy, and raises full, empty and two early-warning flags. A word is accepted on a clock edge where the push strobe is high. A word is removed on an edge where the pop strobe is high. Pushes into a full queue and pops from an empty queue are refused when protection is enabled.

A compile-time parameter selects the read timing. In registered-read (classic) mode, the popped word appears on `rd_data` after the edge that accepted the pop. In fall-through mode, the oldest stored word is already presented on `rd_data` while the queue is non-empty. The pop strobe then advances to the next word. In fall-through mode `rd_data` still comes from a register. A push into the slot that will become the head is forwarded straight into that register, so the design does not rely on a write-before-read memory mode.

Fill tracking is a three-state machine: `FILL_EMPTY`, `FILL_PARTIAL` and `FILL_FULL`. Its transitions are:
- push-only from `FILL_EMPTY` moves to `FILL_PARTIAL`.
- push-only at one below capacity moves `FILL_PARTIAL` to `FILL_FULL`.
- pop-only at one word moves `FILL_PARTIAL` to `FILL_EMPTY`.
- pop-only from `FILL_FULL` moves to `FILL_PARTIAL`.
- every other input combination holds the state.

The synchronous clear returns the queue to `FILL_EMPTY`. When the `ASYNC_RST` parameter is set, the active-low asynchronous reset does the same.

Top module: `sync_fifo_sa`

## Requirements
- R1: After the asynchronous reset or a synchronous clear, `level` is 0, `empty` is 1, `full` is 0 and `rd_data` is all zeros.
- R2: An accepted push without an accepted pop raises `level` by one. An accepted pop without an accepted push lowers it by one. A push and a pop both accepted on the same edge leave it unchanged.
- R3: Words leave the queue in the order in which they were accepted.
- R4: In classic mode (`SHOWAHEAD`=0), `rd_data` takes the popped word at the edge that accepts the pop, and holds its value on edges with no accepted pop.
- R5: In fall-through mode (`SHOWAHEAD`=1), whenever `empty` is 0, `rd_data` equals the oldest stored word. This includes the cycle right after a push into an empty queue.
- R6: `full` is 1 exactly when `level` equals `DEPTH`. With overflow protection, a push while `full` is 1 is ignored, even when a pop is accepted on the same edge.
- R7: `empty` is 1 exactly when `level` is 0. With underflow protection, a pop while `empty` is 1 is ignored, and a push on the same edge is still accepted.
- R8: `almost_full` is 1 when `level` is at least `DEPTH - NF_GAP`.
- R9: `almost_empty` is 1 when `level` is at most `NE_LEVEL`.
- R10: `clear` takes priority over `wr_en` and `rd_en` on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| arst_n | input | 1 | Asynchronous reset, active low; used only when `ASYNC_RST`=1 |
| clear | input | 1 | Synchronous clear, active high |
| wr_en | input | 1 | Push strobe |
| wr_data | input | DW | Word to push |
| rd_en | input | 1 | Pop strobe |
| rd_data | output | DW | Output word (timing set by `SHOWAHEAD`) |
| full | output | 1 | Queue holds `DEPTH` words |
| empty | output | 1 | Queue holds no word |
| almost_full | output | 1 | Occupancy at or above the upper warning level |
| almost_empty | output | 1 | Occupancy at or below the lower warning level |
| level | output | $clog2(DEPTH+1) | Current occupancy |

## Verification
The bound assertions check the flag and occupancy relations on every cycle:
- full and empty agree with the occupancy;
- the occupancy moves by exactly one on a lone push or pop;
- it stays put on refused pushes and pops;
- it drops to zero after a clear.

Only the bench scenarios can show data ordering, the different output timing of the two read modes, and the forwarding of a push into an empty fall-through queue. The bench runs both modes side by side against a queue model.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY   = 2'd0,
        FILL_PARTIAL = 2'd1,
        FILL_FULL    = 2'd2
    } fill_state_t;

endpackage

// File: rtl/fifo_mem.sv
module fifo_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
    import fifo_pkg::*;
#(
    parameter int DEPTH     = 8,
    parameter int NF_GAP    = 1,
    parameter int NE_LEVEL  = 1,
    parameter bit CHECK_OVF = 1'b1,
    parameter bit CHECK_UNF = 1'b1,
    localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] rd_ptr_nxt,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty
);

    fill_state_t   state_q, state_d;
    logic [CW-1:0] count_q, count_d;
    logic [AW-1:0] wp_q, rp_q;
    logic          push_only, pop_only;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Strobe gating by the protection options
    assign wr_ok = wr_en & ~(CHECK_OVF && (state_q == FILL_FULL));
    assign rd_ok = rd_en & ~(CHECK_UNF && (state_q == FILL_EMPTY));
    assign push_only = wr_ok & ~rd_ok;
    assign pop_only  = rd_ok & ~wr_ok;
    assign rd_ptr_nxt = rd_ok ? step_ptr(rp_q) : rp_q;

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: begin
                if (push_only) state_d = FILL_PARTIAL;
            end
            FILL_PARTIAL: begin
                if (push_only && count_q == CW'(DEPTH - 1)) state_d = FILL_FULL;
                else if (pop_only && count_q == CW'(1))      state_d = FILL_EMPTY;
            end
            FILL_FULL: begin
                if (pop_only) state_d = FILL_PARTIAL;
            end
            default: state_d = FILL_EMPTY;
        endcase
    end

    always_comb begin
        count_d = count_q;
        if (push_only && count_q != CW'(DEPTH)) count_d = count_q + 1'b1;
        else if (pop_only && count_q != '0)     count_d = count_q - 1'b1;
    end

    // State register and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
            count_q <= '0;
            wp_q    <= '0;
            rp_q    <= '0;
        end else if (clear) begin
            state_q <= FILL_EMPTY;
            count_q <= '0;
            wp_q    <= '0;
            rp_q    <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (wr_ok) wp_q <= step_ptr(wp_q);
            rp_q <= rd_ptr_nxt;
        end
    end

    // Outputs
    always_comb begin
        full         = (state_q == FILL_FULL);
        empty        = (state_q == FILL_EMPTY);
        almost_full  = (count_q >= CW'(DEPTH - NF_GAP));
        almost_empty = (count_q <= CW'(NE_LEVEL));
        level        = count_q;
        wr_ptr       = wp_q;
        rd_ptr       = rp_q;
    end

endmodule

// File: rtl/fifo_out_stage.sv
module fifo_out_stage #(
    parameter int DW        = 8,
    parameter int AW        = 3,
    parameter bit SHOWAHEAD = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_ok,
    input  logic          rd_ok,
    input  logic [AW-1:0] wr_ptr,
    input  logic [AW-1:0] rd_ptr,
    input  logic [AW-1:0] rd_ptr_nxt,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] dout_q, dout_d;
    logic          load;

    generate
        if (SHOWAHEAD) begin : g_fall_through
            logic hit;
            // A push landing in the slot that is about to become the head
            assign hit       = wr_ok && (wr_ptr == rd_ptr_nxt);
            assign mem_raddr = rd_ptr_nxt;
            assign load      = rd_ok | hit;
            assign dout_d    = hit ? wr_data : mem_rdata;
        end else begin : g_classic
            logic unused_ok;
            assign unused_ok = wr_ok ^ (|wr_ptr) ^ (|rd_ptr_nxt) ^ (|wr_data);
            assign mem_raddr = rd_ptr;
            assign load      = rd_ok;
            assign dout_d    = mem_rdata;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dout_q <= '0;
        else if (clear)   dout_q <= '0;
        else if (load)    dout_q <= dout_d;
    end

    assign rd_data = dout_q;

endmodule

// File: rtl/sync_fifo_sa.sv
module sync_fifo_sa #(
    parameter int DW        = 8,
    parameter int DEPTH     = 8,
    parameter int NF_GAP    = 1,
    parameter int NE_LEVEL  = 1,
    parameter bit SHOWAHEAD = 1'b0,
    parameter bit CHECK_OVF = 1'b1,
    parameter bit CHECK_UNF = 1'b1,
    parameter bit ASYNC_RST = 1'b1,
    localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty,
    output logic [CW-1:0] level
);

    logic          rst_n;
    logic          wr_ok, rd_ok;
    logic [AW-1:0] wr_ptr, rd_ptr, rd_ptr_nxt, mem_raddr;
    logic [DW-1:0] mem_rdata;

    assign rst_n = ASYNC_RST ? arst_n : 1'b1;

    fifo_ctrl #(
        .DEPTH(DEPTH), .NF_GAP(NF_GAP), .NE_LEVEL(NE_LEVEL),
        .CHECK_OVF(CHECK_OVF), .CHECK_UNF(CHECK_UNF)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .wr_en(wr_en), .rd_en(rd_en),
        .wr_ok(wr_ok), .rd_ok(rd_ok),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rd_ptr_nxt(rd_ptr_nxt),
        .level(level), .full(full), .empty(empty),
        .almost_full(almost_full), .almost_empty(almost_empty)
    );

    fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(wr_ok), .waddr(wr_ptr), .wdata(wr_data),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    fifo_out_stage #(.DW(DW), .AW(AW), .SHOWAHEAD(SHOWAHEAD)) u_out (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .wr_ok(wr_ok), .rd_ok(rd_ok),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rd_ptr_nxt(rd_ptr_nxt),
        .wr_data(wr_data), .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr), .rd_data(rd_data)
    );

endmodule

// File: rtl/sync_fifo_sa_chk.sv
module sync_fifo_sa_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          arst_n,
    input logic          clear,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full,
    input logic          empty,
    input logic [CW-1:0] level
);

    // R6
    full_level_chk: assert property (@(posedge clk) disable iff (!arst_n)
        full == (level == CW'(DEPTH)));

    // R7
    empty_level_chk: assert property (@(posedge clk) disable iff (!arst_n)
        empty == (level == '0));

    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!clear && wr_en && !rd_en && !full) |=> level == $past(level) + 1'b1);

    // R2
    pop_step_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!clear && rd_en && !wr_en && !empty) |=> level == $past(level) - 1'b1);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!clear && wr_en && !rd_en && full) |=> full && $stable(level));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (!clear && rd_en && !wr_en && empty) |=> empty && $stable(level));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
        clear |=> empty && !full && level == '0);

endmodule

bind sync_fifo_sa sync_fifo_sa_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .arst_n(arst_n), .clear(clear), .wr_en(wr_en), .rd_en(rd_en),
    .full(full), .empty(empty), .level(level)
);

// File: tb/sync_fifo_sa_test.sv
module sync_fifo_sa_test;

    localparam int DW    = 8;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int NVEC  = 16;

    // {push, pop, data, expected level}
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'hA1, 3'd1},
        {1'b1, 1'b0, 8'hA2, 3'd2},
        {1'b1, 1'b1, 8'hA3, 3'd2},
        {1'b1, 1'b0, 8'hA4, 3'd3},
        {1'b1, 1'b0, 8'hA5, 3'd4},
        {1'b1, 1'b0, 8'hA6, 3'd4},
        {1'b1, 1'b1, 8'hA7, 3'd3},
        {1'b0, 1'b1, 8'h00, 3'd2},
        {1'b0, 1'b1, 8'h00, 3'd1},
        {1'b0, 1'b1, 8'h00, 3'd0},
        {1'b0, 1'b1, 8'h00, 3'd0},
        {1'b1, 1'b1, 8'hA8, 3'd1},
        {1'b1, 1'b1, 8'hA9, 3'd1},
        {1'b0, 1'b1, 8'h00, 3'd0},
        {1'b1, 1'b0, 8'hAA, 3'd1},
        {1'b0, 1'b1, 8'h00, 3'd0}
    };

    logic          clk = 1'b0;
    logic          arst_n = 1'b0;
    logic          clear = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] sa_data, cl_data;
    logic          sa_full, sa_empty, sa_af, sa_ae;
    logic          cl_full, cl_empty, cl_af, cl_ae;
    logic [CW-1:0] sa_level, cl_level;

    int n_checks = 0;
    int n_fail   = 0;
    logic [DW-1:0] model [$];
    logic [DW-1:0] cl_exp = '0;

    always #5 clk = ~clk;

    sync_fifo_sa #(.DW(DW), .DEPTH(DEPTH), .NF_GAP(1), .NE_LEVEL(1), .SHOWAHEAD(1'b1)) uut (
        .clk(clk), .arst_n(arst_n), .clear(clear), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(sa_data), .full(sa_full), .empty(sa_empty),
        .almost_full(sa_af), .almost_empty(sa_ae), .level(sa_level)
    );

    sync_fifo_sa #(.DW(DW), .DEPTH(DEPTH), .NF_GAP(1), .NE_LEVEL(1), .SHOWAHEAD(1'b0)) uut_cl (
        .clk(clk), .arst_n(arst_n), .clear(clear), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(cl_data), .full(cl_full), .empty(cl_empty),
        .almost_full(cl_af), .almost_empty(cl_ae), .level(cl_level)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Compare both instances with the model
    task automatic check_all(input string tag);
        int sz = model.size();
        check({tag, " R2 level sa"}, int'(sa_level), sz);
        check({tag, " R2 level cl"}, int'(cl_level), sz);
        check({tag, " R7 empty"}, int'({sa_empty, cl_empty}), (sz == 0) ? 3 : 0);
        check({tag, " R6 full"}, int'({sa_full, cl_full}), (sz == DEPTH) ? 3 : 0);
        check({tag, " R8 almost_full"}, int'({sa_af, cl_af}), (sz >= DEPTH - 1) ? 3 : 0);
        check({tag, " R9 almost_empty"}, int'({sa_ae, cl_ae}), (sz <= 1) ? 3 : 0);
        check({tag, " R3 R4 classic data"}, int'(cl_data), int'(cl_exp));
        if (sz > 0) check({tag, " R3 R5 head data"}, int'(sa_data), int'(model[0]));
    endtask

    // One edge with the model updated in step
    task automatic step(input logic w, input logic r, input logic [DW-1:0] d);
        bit rok, wok;
        wr_en = w; rd_en = r; wr_data = d;
        rok = r && (model.size() > 0);
        wok = w && (model.size() < DEPTH);
        @(posedge clk);
        #2;
        if (rok) cl_exp = model.pop_front();
        if (wok) model.push_back(d);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 reset level", int'(sa_level) + int'(cl_level), 0);
        check("R1 reset flags", int'({sa_empty, cl_empty, sa_full, cl_full}), 4'b1100);
        check("R1 reset data", int'(sa_data) + int'(cl_data), 0);
        arst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][12], VEC[i][11], VEC[i][10:3]);
            check($sformatf("vec%0d R2 table level", i), int'(sa_level), int'(VEC[i][2:0]));
            check_all($sformatf("vec%0d", i));
        end

        // R10 clear beats push and pop on the same edge
        step(1'b1, 1'b0, 8'hB1);
        step(1'b1, 1'b0, 8'hB2);
        check_all("pre-clear");
        clear = 1'b1; wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'hB3;
        @(posedge clk);
        #2;
        clear = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        model.delete();
        cl_exp = '0;
        check("R10 clear level", int'(sa_level) + int'(cl_level), 0);
        check("R1 clear empty", int'({sa_empty, cl_empty}), 3);
        check("R1 clear data", int'(sa_data) + int'(cl_data), 0);

        // R5 push into empty is visible on the next cycle
        step(1'b1, 1'b0, 8'hC1);
        check("R5 fall-through after one push", int'(sa_data), 8'hC1);
        check("R4 classic holds without pop", int'(cl_data), 0);
        step(1'b1, 1'b0, 8'hC2);
        step(1'b0, 1'b0, 8'h00);
        check_all("idle");
        step(1'b0, 1'b1, 8'h00);
        check_all("pop C1");

        // R1 asynchronous reset in the middle of a stream
        step(1'b1, 1'b0, 8'hD1);
        arst_n = 1'b0;
        #1;
        model.delete();
        cl_exp = '0;
        check("R1 async level", int'(sa_level) + int'(cl_level), 0);
        check("R1 async empty", int'({sa_empty, cl_empty}), 3);
        check("R1 async data", int'(sa_data) + int'(cl_data), 0);
        @(posedge clk);
        #2;
        arst_n = 1'b1;
        step(1'b1, 1'b0, 8'hE1);
        check_all("after async");

        finish_run();
    end

endmodule